// File: doc/BRIEF.md
# Streaming Pattern Checker with Channel Statistics

The block sits at the sink end of a multi-channel test stream. Each beat carries a fixed number of byte symbols together with a channel number, start-of-packet and end-of-packet flags and an error sideband. For every channel the checker tracks whether a packet is open and which byte value it expects next. The expected pattern is an incrementing byte sequence that restarts from the first symbol of every packet. Symbol mismatches and framing faults are detected, and the first fault is held in a single descriptor word tagged with its channel.

Per-channel packet, symbol and data-error counters saturate at their maximum. Software picks a channel through a select register and reads that channel's counters back through two words. Acceptance is paced by a pseudorandom throttle on the ready output, so a generator can be tested against a sink that stalls.

Registers: word 0 status (read-only), word 1 control, word 2 exception descriptor, word 3 channel select, word 4 channel counts. Register reads are combinational on `reg_rdata` while `reg_rd` is high. Writes take effect at the clock edge.

Top module: `pattern_checker`

## Requirements
- R1: Word 0 reads the constant 0x0065 in [15:0], the channel count in [23:16], symbols per beat in [30:24] and 1 in bit 31. With the defaults (4 channels, 2 symbols) it reads 0x82040065.
- R2: Control word 1 has enable in bit 0, throttle (0..256) in [16:8] and soft reset in bit 17. `in_ready` is low when enable is 0, when soft reset is set or when throttle is 0. With throttle 256 and enable set, `in_ready` is high on every cycle. Intermediate values let a proportional share of cycles through, chosen by a pseudorandom comparison.
- R3: Symbol k of a beat (bits [8k+7:8k]) must equal base+k modulo 256. On a start-of-packet beat the base is that beat's symbol 0; otherwise it is the value that follows the channel's previous beat. Any mismatch on an accepted beat sets descriptor bit 0 and adds one to that channel's error count.
- R4: An accepted beat without start-of-packet on a channel with no open packet sets descriptor bit 1 (missing start). An accepted end-of-packet beat closes the channel's packet. Any other accepted beat leaves it open.
- R5: An accepted start-of-packet beat on a channel whose packet is already open sets descriptor bit 2 (missing end).
- R6: Only the first fault is held; later faults leave the descriptor unchanged. A read of word 2 returns the descriptor and then clears it. Word 2 reads 0 when no fault is held. Descriptor bits [31:24] give the channel of the fault.
- R7: A non-zero error sideband on an accepted beat is a fault. Its value is recorded in descriptor [15:8].
- R8: Word 3 holds the selected channel in [7:0] and returns that channel's error count in [31:16]. Word 4 returns its packet count (one per accepted end-of-packet beat) in [15:0] and its symbol count in [31:16]. The symbol count grows by the symbols per beat on every accepted beat.
- R9: All counters saturate at 0xFFFF instead of wrapping.
- R10: While soft reset is set, all counters, packet states, expected values and the descriptor are held at zero. Counting resumes once the bit is written back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the descriptor when reading word 2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Throttled ready |
| in_data | input | SYMS*8 | Beat symbols, symbol 0 in the low byte |
| in_chan | input | $clog2(NCH) | Beat channel |
| in_sop | input | 1 | Start of packet |
| in_eop | input | 1 | End of packet |
| in_err | input | 8 | Error sideband |

## Verification
A beat is accepted at the rising edge where `in_valid` and `in_ready` are both high. Its counter and descriptor effects are visible on `reg_rdata` from the next falling edge. The driver therefore changes inputs only on falling edges and performs every register read one cycle after the last beat it depends on. The read monitor samples `reg_rdata` 1 ns after the falling edge on which a read was raised, and the clear-on-read takes effect at the following rising edge. `in_ready` is combinational from the control register, so it is checked on the falling edge after the control write.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    localparam logic [15:0] PCHK_ID = 16'h0065;
    localparam int CNT_W = 16;
    localparam int ERR_W = 8;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_CTRL   = 3'd1,
        A_EXC    = 3'd2,
        A_SEL    = 3'd3,
        A_CNT    = 3'd4
    } addr_e;

    typedef struct packed {
        logic [7:0]       chan;
        logic [7:0]       rsv_hi;
        logic [ERR_W-1:0] err;
        logic [4:0]       rsv_lo;
        logic             miss_eop;
        logic             miss_sop;
        logic             data_err;
    } exc_t;

    typedef struct packed {
        logic       srst;
        logic [8:0] throttle;
        logic       enable;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] v, logic [CNT_W-1:0] a);
        logic [CNT_W:0] s;
        s = {1'b0, v} + {1'b0, a};
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pchk_throttle.sv
module pchk_throttle #(
    parameter int          LFSR_W = 16,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       srst,
    input  logic [8:0] throttle,
    output logic       ready
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    assign fb = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-3] ^ lfsr_q[LFSR_W-4] ^ lfsr_q[LFSR_W-6];

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= SEED[LFSR_W-1:0];
        else     lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
    end

    always_comb begin
        if (!enable || srst)   ready = 1'b0;
        else if (throttle[8])  ready = 1'b1;
        else                   ready = (lfsr_q[7:0] < throttle[7:0]);
    end

    // R2: the shift register never locks up at zero
    p_lfsr_live_r2: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0);
endmodule

// File: rtl/pchk_lane.sv
module pchk_lane #(
    parameter int SYMS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              beat,
    input  logic              sop,
    input  logic              eop,
    input  logic [SYMS*8-1:0] data,
    output logic              mism,
    output logic              miss_sop,
    output logic              miss_eop
);
    logic       in_pkt_q;
    logic [7:0] exp_q;
    logic [7:0] base;

    assign base     = sop ? data[7:0] : exp_q;
    assign miss_sop = !in_pkt_q && !sop;
    assign miss_eop = in_pkt_q && sop;

    always_comb begin
        mism = 1'b0;
        for (int k = 0; k < SYMS; k++) begin
            if (data[k*8 +: 8] != base + 8'(k)) mism = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_pkt_q <= 1'b0;
            exp_q    <= 8'd0;
        end else if (beat) begin
            in_pkt_q <= !eop;
            exp_q    <= base + 8'(SYMS);
        end
    end

    // R4: an accepted end-of-packet beat closes the packet
    p_pkt_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (beat && eop && !clr) |=> !in_pkt_q);
    // R5: an accepted start-of-packet beat without end leaves the packet open
    p_pkt_open_r5: assert property (@(posedge clk) disable iff (rst)
        (beat && sop && !eop && !clr) |=> in_pkt_q);
endmodule

// File: rtl/pchk_stats.sv
module pchk_stats
    import pchk_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int SYMS = 2,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             beat,
    input  logic [CH_W-1:0]  chan,
    input  logic             mism,
    input  logic             eop,
    input  logic [7:0]       sel,
    output logic [CNT_W-1:0] pkt_o,
    output logic [CNT_W-1:0] sym_o,
    output logic [CNT_W-1:0] err_o
);
    localparam logic [CNT_W-1:0] SYM_INC = CNT_W'(SYMS);

    logic [CNT_W-1:0] pkt_q [NCH];
    logic [CNT_W-1:0] sym_q [NCH];
    logic [CNT_W-1:0] err_q [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = beat && (chan == CH_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                pkt_q[i] <= '0;
                sym_q[i] <= '0;
                err_q[i] <= '0;
            end else if (hit) begin
                sym_q[i] <= sat_add(sym_q[i], SYM_INC);
                if (eop)  pkt_q[i] <= sat_add(pkt_q[i], CNT_W'(1));
                if (mism) err_q[i] <= sat_add(err_q[i], CNT_W'(1));
            end
        end

        // R9: a saturated symbol counter stays saturated
        p_sym_sat_r9: assert property (@(posedge clk) disable iff (rst)
            (sym_q[i] == {CNT_W{1'b1}} && !clr) |=> sym_q[i] == {CNT_W{1'b1}});
        // R10: soft reset empties the counters
        p_clear_r10: assert property (@(posedge clk) disable iff (rst)
            clr |=> (sym_q[i] == '0 && pkt_q[i] == '0 && err_q[i] == '0));
    end

    always_comb begin
        if (sel < 8'(NCH)) begin
            pkt_o = pkt_q[sel[CH_W-1:0]];
            sym_o = sym_q[sel[CH_W-1:0]];
            err_o = err_q[sel[CH_W-1:0]];
        end else begin
            pkt_o = '0;
            sym_o = '0;
            err_o = '0;
        end
    end
endmodule

// File: rtl/pattern_checker.sv
module pattern_checker
    import pchk_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int SYMS = 2,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SYMS*8-1:0] in_data,
    input  logic [CH_W-1:0]   in_chan,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [ERR_W-1:0]  in_err
);
    localparam logic [31:0] STATUS_WORD = {1'b1, 7'(SYMS), 8'(NCH), PCHK_ID};

    ctrl_t            ctrl_q;
    logic [7:0]       sel_q;
    exc_t             desc_q;
    logic             pend_q;
    logic             fire, rd_clear, exc_now;
    logic [NCH-1:0]   l_mism, l_msop, l_meop;
    logic             c_mism, c_msop, c_meop;
    logic [CNT_W-1:0] pkt_c, sym_c, err_c;

    assign fire     = in_valid && in_ready;
    assign rd_clear = reg_rd && (reg_addr == A_EXC);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                ctrl_q.enable   <= reg_wdata[0];
                ctrl_q.throttle <= reg_wdata[16:8];
                ctrl_q.srst     <= reg_wdata[17];
            end
            if (reg_addr == A_SEL) sel_q <= reg_wdata[7:0];
        end
    end

    pchk_throttle u_thr (
        .clk(clk), .rst(rst), .enable(ctrl_q.enable), .srst(ctrl_q.srst),
        .throttle(ctrl_q.throttle), .ready(in_ready)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        pchk_lane #(.SYMS(SYMS)) u_lane (
            .clk(clk), .rst(rst), .clr(ctrl_q.srst),
            .beat(fire && (in_chan == CH_W'(i))),
            .sop(in_sop), .eop(in_eop), .data(in_data),
            .mism(l_mism[i]), .miss_sop(l_msop[i]), .miss_eop(l_meop[i])
        );
    end

    assign c_mism  = l_mism[in_chan];
    assign c_msop  = l_msop[in_chan];
    assign c_meop  = l_meop[in_chan];
    assign exc_now = fire && (c_mism || c_msop || c_meop || (in_err != '0));

    pchk_stats #(.NCH(NCH), .SYMS(SYMS)) u_stats (
        .clk(clk), .rst(rst), .clr(ctrl_q.srst), .beat(fire), .chan(in_chan),
        .mism(c_mism), .eop(in_eop), .sel(sel_q),
        .pkt_o(pkt_c), .sym_o(sym_c), .err_o(err_c)
    );

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.srst) begin
            pend_q <= 1'b0;
            desc_q <= '0;
        end else if (exc_now && (!pend_q || rd_clear)) begin
            pend_q          <= 1'b1;
            desc_q          <= '0;
            desc_q.data_err <= c_mism;
            desc_q.miss_sop <= c_msop;
            desc_q.miss_eop <= c_meop;
            desc_q.err      <= in_err;
            desc_q.chan     <= 8'(in_chan);
        end else if (rd_clear) begin
            pend_q <= 1'b0;
            desc_q <= '0;
        end
    end

    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = STATUS_WORD;
            A_CTRL:   reg_rdata = {14'd0, ctrl_q.srst, ctrl_q.throttle, 7'd0, ctrl_q.enable};
            A_EXC:    reg_rdata = pend_q ? desc_q : 32'd0;
            A_SEL:    reg_rdata = {err_c, 8'd0, sel_q};
            A_CNT:    reg_rdata = {sym_c, pkt_c};
            default:  reg_rdata = 32'd0;
        endcase
    end

    // R6: a held fault is not overwritten until it is read
    p_first_only_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !rd_clear && !ctrl_q.srst) |=> $stable(desc_q));
    // R7: a sideband error on an accepted beat is captured when none is held
    p_sideband_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && in_err != '0 && !pend_q && !ctrl_q.srst) |=> (pend_q && desc_q.err == $past(in_err)));
    // R2: writing enable low stops acceptance on the next cycle
    p_ready_off_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[0]) |=> !in_ready);
endmodule

// File: tb/pattern_checker_test.sv
module pattern_checker_test;
    localparam int NCH = 4;
    localparam int SYMS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        in_valid = 1'b0, in_ready;
    logic [15:0] in_data = '0;
    logic [1:0]  in_chan = '0;
    logic        in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_err = '0;

    int checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        done = 1'b0;

    always #2 clk = ~clk;

    pattern_checker #(.NCH(NCH), .SYMS(SYMS)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_chan(in_chan), .in_sop(in_sop),
        .in_eop(in_eop), .in_err(in_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each register read against the scoreboard queue
    always @(negedge clk) begin
        #1;
        if (reg_rd) begin
            if (exp_q.size() == 0) check("read with no expectation", 32'hx, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic beat(logic [1:0] ch, logic [7:0] d0, logic [7:0] d1,
                        logic sop, logic eop, logic [7:0] err);
        @(negedge clk);
        in_valid = 1'b1; in_chan = ch; in_data = {d1, d0};
        in_sop = sop; in_eop = eop; in_err = err;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = '0;
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 ready low after reset", {31'd0, in_ready}, 32'd0);
        rd(3'd0, 32'h82040065, "R1 status word");
        rd(3'd2, 32'h0, "R6 descriptor empty after reset");
        rd(3'd4, 32'h0, "R8 counts zero after reset");

        wr(3'd1, 32'h00010001);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R2 full throttle ready", {31'd0, in_ready}, 32'd1);
        end

        // clean packet on channel 1
        beat(2'd1, 8'h10, 8'h11, 1'b1, 1'b0, 8'h0);
        beat(2'd1, 8'h12, 8'h13, 1'b0, 1'b0, 8'h0);
        beat(2'd1, 8'h14, 8'h15, 1'b0, 1'b1, 8'h0);
        wr(3'd3, 32'd1);
        rd(3'd4, 32'h00060001, "R8 ch1 packets and symbols");
        rd(3'd3, 32'h00000001, "R3 ch1 no data errors");
        rd(3'd2, 32'h0, "R3 no fault on clean packet");

        // mismatch on channel 2
        beat(2'd2, 8'h20, 8'h21, 1'b1, 1'b0, 8'h0);
        beat(2'd2, 8'h22, 8'h99, 1'b0, 1'b1, 8'h0);
        rd(3'd2, 32'h02000001, "R3 mismatch descriptor");
        rd(3'd2, 32'h0, "R6 descriptor cleared by read");
        wr(3'd3, 32'd2);
        rd(3'd3, 32'h00010002, "R3 ch2 error count");

        // missing start on channel 3
        beat(2'd3, 8'h00, 8'h01, 1'b0, 1'b1, 8'h0);
        rd(3'd2, 32'h03000002, "R4 missing start descriptor");

        // missing end on channel 0, then a second fault that must not replace it
        beat(2'd0, 8'h00, 8'h01, 1'b1, 1'b0, 8'h0);
        beat(2'd0, 8'h40, 8'h41, 1'b1, 1'b0, 8'h0);
        beat(2'd0, 8'h42, 8'h43, 1'b0, 1'b1, 8'h5A);
        rd(3'd2, 32'h00000004, "R5 missing end descriptor, R6 first only");
        rd(3'd2, 32'h0, "R6 empty after read");
        wr(3'd3, 32'd0);
        rd(3'd4, 32'h00060001, "R8 ch0 counts");
        rd(3'd3, 32'h00000000, "R3 resync on start, ch0 no errors");

        beat(2'd1, 8'h30, 8'h31, 1'b1, 1'b1, 8'h5A);
        rd(3'd2, 32'h01005A00, "R7 sideband error descriptor");

        // saturate channel 3 symbol count: 2 + 2*32767 exceeds 0xFFFF
        for (int i = 0; i < 32767; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_chan = 2'd3;
            in_data = {8'(2*i + 1), 8'(2*i)};
            in_sop = (i == 0); in_eop = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
        wr(3'd3, 32'd3);
        rd(3'd4, 32'hFFFF0001, "R9 symbol count saturates");
        rd(3'd3, 32'h00000003, "R3 long run no errors");
        rd(3'd2, 32'h0, "R4 long run no fault");

        // soft reset
        wr(3'd1, 32'h00030001);
        @(negedge clk);
        check("R10 ready low in soft reset", {31'd0, in_ready}, 32'd0);
        rd(3'd4, 32'h0, "R10 counts cleared");
        wr(3'd1, 32'h00010001);
        @(negedge clk);
        check("R10 ready back after soft reset", {31'd0, in_ready}, 32'd1);
        rd(3'd4, 32'h0, "R10 counts stay zero after release");
        beat(2'd3, 8'h05, 8'h06, 1'b1, 1'b1, 8'h0);
        rd(3'd4, 32'h00020001, "R10 counting resumes");

        // throttle zero and enable low
        wr(3'd1, 32'h00000001);
        begin
            int hi = 0;
            for (int i = 0; i < 32; i++) begin
                @(negedge clk);
                if (in_ready) hi++;
            end
            check("R2 throttle zero stops", 32'(hi), 32'd0);
        end
        wr(3'd1, 32'h00010000);
        @(negedge clk);
        check("R2 enable low stops", {31'd0, in_ready}, 32'd0);

        // throttle at half rate
        wr(3'd1, 32'h00008001);
        begin
            int hi = 0;
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                if (in_ready) hi++;
            end
            check("R2 half throttle in range", {31'd0, (hi >= 64 && hi <= 192)}, 32'd1);
            check("R2 half throttle not full", {31'd0, (hi < 256)}, 32'd1);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule